// File: doc/BRIEF.md
# Laser Safety Fault Latch Controller

This block decides, every clock cycle, whether the bias and modulation current generators of a laser transmitter may run. Its inputs are a software enable bit, a hardware disable pin, a fault-arm bit and three fault sources. Two of the fault sources are analog comparator results that arrive as digital flags: an overvoltage on the bias monitor node, and a photodiode current above its overcurrent limit. The third fault source is computed inside the block. It is raised when the bias DAC code falls to less than half of its previous value in a single step.

When any fault is seen while the arm bit is set, both output enables are switched off in the same cycle. The fault output is then latched. A latched fault can only be cleared by a disable request that lasts at least a set number of clock cycles. A disable request is either the disable pin high or the enable bit low. While the request is held, the fault output reads low. When the request is released, the outputs come back only after a settling delay. If the fault cause is still present at that point, the latch sets again and the outputs stay off.

Top module: `laser_fault_guard`

## Requirements
- R1: While reset is asserted and right after it, `bias_en`, `mod_en` and `fault_out` are all 0.
- R2: In any cycle where `dis_pin` is 1 or `ena_bit` is 0, `bias_en` and `mod_en` are 0 in that same cycle.
- R3: Take cycle 0 as the first cycle with `dis_pin`=0 and `ena_bit`=1. If no fault is latched, both enables stay 0 through cycle ON_DLY and become 1 in cycle ON_DLY+1.
- R4: Suppose `arm_bit`=1 and `mon_ovr`=1 in a running cycle. Both enables are 0 in that cycle and `fault_out` is 1 from the next cycle on. `fault_out` stays 1 after `mon_ovr` returns to 0, and the enables stay 0.
- R5: The photodiode flag `pd_ovr` has the same effect as `mon_ovr`, including when it is only one cycle long.
- R6: A step fault exists in a cycle where 2 × `bias_code` < the value `bias_code` had in the previous cycle. Codes are treated as unsigned. With `arm_bit`=1, a step fault gates the enables in that cycle and latches `fault_out` at the next edge. A new code of exactly half is not a fault.
- R7: With `arm_bit`=0, none of the three fault sources sets `fault_out` or changes the enables.
- R8: While a disable request is held, `fault_out` reads 0. A latched fault that is not cleared reads 1 again in the cycle the request is released.
- R9: A disable request held for RST_CYC or more consecutive cycles clears the latch. One held for RST_CYC−1 cycles or fewer does not.
- R10: If a fault flag is still 1 when a clearing disable request is released, `fault_out` is 1 again one cycle after the release, and the enables stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ena_bit | input | 1 | Software enable; 0 requests disable |
| arm_bit | input | 1 | Fault detection arm |
| dis_pin | input | 1 | Hardware disable; 1 requests disable |
| mon_ovr | input | 1 | Bias monitor overvoltage comparator flag |
| pd_ovr | input | 1 | Photodiode overcurrent comparator flag |
| bias_code | input | DAC_W | Current bias DAC code |
| bias_en | output | 1 | Bias current generator enable |
| mod_en | output | 1 | Modulation current generator enable |
| fault_out | output | 1 | Latched fault flag, masked during disable |

## Verification
The step-drop fault is the hardest case to reach from the ports. It depends on a pair of codes in consecutive cycles. The previous code cannot be set directly, and every transition into it could itself raise a fault. The bench therefore loads each "old" code with the arm bit low, so that the transition into it cannot latch anything. It then raises the arm bit in the same cycle it applies the "new" code. The sweep covers every old code against new codes near and at the half boundary. After each expected fault, the bench runs a timed disable to clear the latch.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  typedef enum logic [1:0] {
    LFG_OFF  = 2'd0,
    LFG_WAKE = 2'd1,
    LFG_RUN  = 2'd2
  } lfg_state_e;
endpackage

// File: rtl/lfg_step_drop.sv
// Flags a bias code that falls below half of the code seen one cycle earlier.
module lfg_step_drop #(
  parameter int DAC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DAC_W-1:0] code,
  output logic             drop
);
  localparam int CMP_W = DAC_W + 1;

  logic [DAC_W-1:0] prev_q;
  logic [DAC_W-1:0] prev_d;
  logic [CMP_W-1:0] twice_new;
  logic [CMP_W-1:0] old_ext;

  always_comb begin
    prev_d    = code;
    twice_new = {code, 1'b0};
    old_ext   = {1'b0, prev_q};
    drop      = (twice_new < old_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/lfg_dwell_timer.sv
// Counts consecutive cycles with run high; hit marks the LIMIT-th such cycle and stays high.
module lfg_dwell_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    hit    = run && (cnt_q == LAST);
    cnt_en = !run || (cnt_q != LAST);
    cnt_d  = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lfg_sequencer.sv
// Output state machine plus the fault latch.
module lfg_sequencer
  import lfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dreq,
  input  logic       armed_fault,
  input  logic       clr_hit,
  input  logic       wake_hit,
  output lfg_state_e state,
  output logic       out_on,
  output logic       flag
);
  lfg_state_e st_q, st_d;
  logic       lat_q, lat_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LFG_OFF:  if (!dreq) st_d = LFG_WAKE;
      LFG_WAKE: begin
        if (dreq)          st_d = LFG_OFF;
        else if (wake_hit) st_d = LFG_RUN;
      end
      LFG_RUN:  if (dreq) st_d = LFG_OFF;
      default:  st_d = LFG_OFF;
    endcase
  end

  always_comb begin
    lat_d = lat_q;
    if (clr_hit)                  lat_d = 1'b0;
    else if (armed_fault && !dreq) lat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LFG_OFF;
      lat_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      lat_q <= lat_d;
    end
  end

  always_comb begin
    state  = st_q;
    out_on = (st_q == LFG_RUN) && !lat_q && !armed_fault && !dreq;
    flag   = lat_q && !dreq;
  end
endmodule

// File: rtl/laser_fault_guard.sv
module laser_fault_guard
  import lfg_pkg::*;
#(
  parameter int DAC_W   = 8,
  parameter int RST_CYC = 250,
  parameter int ON_DLY  = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ena_bit,
  input  logic             arm_bit,
  input  logic             dis_pin,
  input  logic             mon_ovr,
  input  logic             pd_ovr,
  input  logic [DAC_W-1:0] bias_code,
  output logic             bias_en,
  output logic             mod_en,
  output logic             fault_out
);
  logic       dreq;
  logic       step_drop;
  logic       armed_fault;
  logic       clr_hit;
  logic       wake_hit;
  logic       wake_run;
  logic       out_on;
  lfg_state_e state;

  always_comb begin
    dreq        = dis_pin || !ena_bit;
    armed_fault = arm_bit && (mon_ovr || pd_ovr || step_drop);
    wake_run    = (state == LFG_WAKE) && !dreq;
  end

  lfg_step_drop #(.DAC_W(DAC_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .code(bias_code), .drop(step_drop)
  );

  lfg_dwell_timer #(.LIMIT(RST_CYC)) u_clr_tmr (
    .clk(clk), .rst_n(rst_n), .run(dreq), .hit(clr_hit)
  );

  lfg_dwell_timer #(.LIMIT(ON_DLY)) u_wake_tmr (
    .clk(clk), .rst_n(rst_n), .run(wake_run), .hit(wake_hit)
  );

  lfg_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .armed_fault(armed_fault),
    .clr_hit(clr_hit), .wake_hit(wake_hit), .state(state),
    .out_on(out_on), .flag(fault_out)
  );

  always_comb begin
    bias_en = out_on;
    mod_en  = out_on;
  end
endmodule

// File: rtl/laser_fault_guard_sva.sv
module laser_fault_guard_sva (
  input logic clk,
  input logic rst_n,
  input logic ena_bit,
  input logic arm_bit,
  input logic dis_pin,
  input logic mon_ovr,
  input logic pd_ovr,
  input logic bias_en,
  input logic mod_en,
  input logic fault_out
);
  p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_pin || !ena_bit) |-> (!bias_en && !mod_en));

  p_flag_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_pin || !ena_bit) |-> !fault_out);

  p_armed_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_bit && (mon_ovr || pd_ovr)) |-> (!bias_en && !mod_en));

  p_latch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_out |=> (fault_out || dis_pin || !ena_bit));

  p_unarmed_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_bit && !dis_pin && ena_bit && !fault_out) |=> !fault_out);

  p_rise_needs_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bias_en) |-> $past(ena_bit && !dis_pin));

  p_enables_paired_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bias_en == mod_en);
endmodule

bind laser_fault_guard laser_fault_guard_sva u_sva (
  .clk(clk), .rst_n(rst_n), .ena_bit(ena_bit), .arm_bit(arm_bit),
  .dis_pin(dis_pin), .mon_ovr(mon_ovr), .pd_ovr(pd_ovr),
  .bias_en(bias_en), .mod_en(mod_en), .fault_out(fault_out)
);

// File: tb/laser_fault_guard_test.sv
`timescale 1ns/1ps
module laser_fault_guard_test;
  localparam int DAC_W = 8;
  localparam int RST_CYC = 8;
  localparam int ON_DLY = 4;

  logic clk = 1'b0;
  logic rst_n, ena_bit, arm_bit, dis_pin, mon_ovr, pd_ovr;
  logic [DAC_W-1:0] bias_code;
  logic bias_en, mod_en, fault_out;
  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  laser_fault_guard #(.DAC_W(DAC_W), .RST_CYC(RST_CYC), .ON_DLY(ON_DLY)) uut (
    .clk(clk), .rst_n(rst_n), .ena_bit(ena_bit), .arm_bit(arm_bit),
    .dis_pin(dis_pin), .mon_ovr(mon_ovr), .pd_ovr(pd_ovr),
    .bias_code(bias_code), .bias_en(bias_en), .mod_en(mod_en),
    .fault_out(fault_out)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_out(input string req, input logic exp);
    chk(req, bias_en, exp);
    chk(req, mod_en, exp);
  endtask

  // release disable and verify the settling delay (R3)
  task automatic bring_up();
    ena_bit = 1'b1;
    dis_pin = 1'b0;
    for (int k = 0; k <= ON_DLY; k++) begin
      #1 chk_out("R3 still settling", 1'b0);
      tick();
    end
    #1 chk_out("R3 on after delay", 1'b1);
  endtask

  // timed disable of RST_CYC cycles through the enable bit
  task automatic clear_pulse();
    ena_bit = 1'b0;
    repeat (RST_CYC) tick();
    ena_bit = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nvec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ena_bit = 1'b0; arm_bit = 1'b0; dis_pin = 1'b0;
    mon_ovr = 1'b0; pd_ovr = 1'b0; bias_code = '0;
    repeat (3) tick();
    #1 chk_out("R1 in reset", 1'b0);
    chk("R1 flag in reset", fault_out, 1'b0);
    rst_n = 1'b1;
    tick();
    #1 chk_out("R1 after reset", 1'b0);
    chk("R1 flag after reset", fault_out, 1'b0);

    bring_up();

    // R2: all four combinations of the two disable sources
    for (int c = 0; c < 4; c++) begin
      dis_pin = c[0];
      ena_bit = c[1];
      #1 chk_out("R2 gating", (c == 2) ? 1'b1 : 1'b0);
      tick();
      if (c != 2) bring_up();
    end

    // R7: unarmed faults have no effect
    arm_bit = 1'b0;
    mon_ovr = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1 chk_out("R7 mon unarmed", 1'b1);
      chk("R7 flag unarmed", fault_out, 1'b0);
      tick();
    end
    mon_ovr = 1'b0; pd_ovr = 1'b1;
    tick();
    #1 chk_out("R7 pd unarmed", 1'b1);
    pd_ovr = 1'b0; bias_code = 8'd200;
    tick();
    bias_code = 8'd10;
    #1 chk_out("R7 drop unarmed", 1'b1);
    tick();
    #1 chk("R7 flag after drop", fault_out, 1'b0);

    // R4: monitor overvoltage, armed
    arm_bit = 1'b1;
    mon_ovr = 1'b1;
    #1 chk_out("R4 same-cycle kill", 1'b0);
    tick();
    #1 chk("R4 flag latched", fault_out, 1'b1);
    mon_ovr = 1'b0;
    tick();
    #1 chk("R4 flag held", fault_out, 1'b1);
    chk_out("R4 outputs held off", 1'b0);

    // R8/R9: sweep of disable pulse lengths
    for (int len = 1; len <= RST_CYC + 1; len++) begin
      ena_bit = 1'b0;
      for (int i = 0; i < len; i++) begin
        #1 chk("R8 flag masked", fault_out, 1'b0);
        tick();
      end
      ena_bit = 1'b1;
      #1 chk("R9 latch after pulse", fault_out, (len < RST_CYC) ? 1'b1 : 1'b0);
      if (len < RST_CYC) begin
        chk("R8 flag back", fault_out, 1'b1);
        repeat (ON_DLY + 2) tick();
        #1 chk_out("R9 short pulse keeps off", 1'b0);
      end else begin
        bring_up();
        pd_ovr = 1'b1;
        #1 chk_out("R5 pd kill", 1'b0);
        tick();
        pd_ovr = 1'b0;
        #1 chk("R5 pd latched", fault_out, 1'b1);
        tick();
        #1 chk("R5 pd held", fault_out, 1'b1);
      end
    end

    // R10: cause still present at release
    mon_ovr = 1'b1;
    clear_pulse();
    #1 chk("R10 release cycle", fault_out, 1'b0);
    tick();
    #1 chk("R10 reasserted", fault_out, 1'b1);
    repeat (ON_DLY + 2) tick();
    #1 chk_out("R10 outputs off", 1'b0);
    chk("R10 flag stays", fault_out, 1'b1);
    mon_ovr = 1'b0;
    clear_pulse();
    bring_up();

    // R6: step-drop sweep over every previous code
    for (int old = 0; old < 256; old++) begin
      for (int j = 0; j < 6; j++) begin
        int nw;
        logic exp;
        case (j)
          0: nw = (old >= 2) ? (old / 2) - 1 : 0;
          1: nw = old / 2;
          2: nw = old / 2 + 1;
          3: nw = 0;
          4: nw = 255;
          default: nw = old;
        endcase
        exp = (nw * 2 < old);
        arm_bit = 1'b0;
        bias_code = DAC_W'(old);
        tick();
        arm_bit = 1'b1;
        bias_code = DAC_W'(nw);
        #1 chk_out("R6 step gate", !exp);
        tick();
        #1 chk("R6 step latch", fault_out, exp);
        if (exp) begin
          arm_bit = 1'b0;
          clear_pulse();
          repeat (ON_DLY + 1) tick();
          #1 chk_out("R6 recovered", 1'b1);
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule